// File: doc/BRIEF.md
# Write-Only Serial Clock-Enable Controller

This block fans one input clock out to ten outputs. A two-wire serial bus sets which outputs run. The bus is I2C. The block is a receive-only slave: it oversamples SCL and SDA with a fast system clock, recognises START and STOP, and checks the address byte. It takes in a fixed train of bytes and acknowledges each one by pulling SDA low through an open-drain control, `sda_pull`.

After the address byte, two filler bytes must arrive and are acknowledged. They carry no meaning. The next bytes load three enable registers in a fixed order, first to last, with no sub-addressing and no readback. An enabled output copies the input clock without inversion. A disabled output sits low. A global drive-enable pin releases all ten outputs to high impedance, and a per-output drive control (`clk_oe`) is brought out for the pad ring. A new enable pattern is handed to the gates only on a falling edge of the input clock, so switching an output on or off never cuts a pulse short.

Every pin is a plain level signal. The block has no streaming interface and no handshake.

Top module: `ckbank_i2c_ctrl`

## Requirements
- R1: Only the address byte 0xD2 (7-bit address 1101001 followed by a low R/W bit) is acknowledged. Any other first byte, including 0xD3, gets no acknowledge, and the receiver ignores the bus until the next START.
- R2: Bytes are 8 bits, MSB first. An acknowledge pulls SDA low (`sda_pull` = 1) from the falling SCL edge after bit 8 until the falling edge that ends the ninth pulse. It is never raised while SCL is high.
- R3: SDA falling while SCL is high is a START. It restarts the sequence at the address byte and releases SDA. SDA rising while SCL is high is a STOP and ends the transfer. Bytes clocked after a STOP and before the next START are ignored.
- R4: The two bytes after the address are acknowledged but change no enable.
- R5: The bytes after those two load enable register 0, then register 1, then register 2. A transfer that stops early leaves the registers it did not reach unchanged.
- R6: Register 0 bits 3..0 drive outputs 3..0. Register 1 bits 7..4 drive outputs 7..4. Register 2 bit 7 drives output 9 and bit 6 drives output 8. All other bits are ignored. A 1 means enabled.
- R7: After reset all ten outputs are enabled.
- R8: An enabled output equals the input clock. A disabled output is 0.
- R9: With `drive_en` low, every `clk_oe` bit is 0 and every `clk_out` bit is 0, whatever the registers hold.
- R10: A written enable value reaches the outputs only at a falling edge of the input clock, so no output pulse is shorter than the input clock's high phase.
- R11: Bytes after the third register byte are not acknowledged and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock as seen on the bus |
| sda_in | input | 1 | Serial data as seen on the bus (wired-AND level) |
| sda_pull | output | 1 | 1 = pull SDA low (acknowledge) |
| clk_src | input | 1 | Clock to be distributed |
| drive_en | input | 1 | 0 = all outputs high impedance |
| clk_out | output | 10 | Gated clock outputs |
| clk_oe | output | 10 | Per-output pad drive enable |

## Verification
Two functions can land in the same cycle: a register byte completing on the bus, and the input clock being high. That would be a write meeting an output in the middle of a pulse. The bench runs the input clock at a period unrelated to the byte time, so over a sweep of sixteen enable patterns the register strobes fall at many different points of the clock's phase. A monitor measures every high pulse on every output and flags any pulse shorter than the input clock's high phase. An assertion in the enable bank checks that the applied pattern never moves while the input clock stays high.

// File: rtl/ckb_pkg.sv
package ckb_pkg;
  localparam int NUM_OUT    = 10;
  localparam int NUM_REGS   = 3;
  localparam int BYTE_W     = 8;
  localparam int SKIP_BYTES = 2;
  localparam int REG_IDX_W  = $clog2(NUM_REGS);

  typedef enum logic [1:0] {PH_IDLE, PH_BITS, PH_ACK} rx_phase_t;

  typedef struct packed {
    logic                 stb;
    logic [REG_IDX_W-1:0] idx;
    logic [BYTE_W-1:0]    data;
  } reg_wr_t;
endpackage

// File: rtl/ckb_bus_sync.sv
module ckb_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/ckb_i2c_rx.sv
module ckb_i2c_rx
  import ckb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1101001
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_s,
  input  logic    sda_s,
  input  logic    scl_rise,
  input  logic    scl_fall,
  input  logic    start_det,
  input  logic    stop_det,
  output logic    sda_pull,
  output reg_wr_t wr
);
  localparam logic [BYTE_W-1:0] ADDR_BYTE = {DEV_ADDR, 1'b0};
  localparam int FIRST_DATA = 1 + SKIP_BYTES;
  localparam int LAST_IDX   = FIRST_DATA + NUM_REGS;
  localparam int IDX_W      = $clog2(LAST_IDX + 1);

  rx_phase_t         phase;
  logic [2:0]        bit_cnt;
  logic [BYTE_W-2:0] shreg;
  logic [IDX_W-1:0]  byte_idx;
  logic              ack_pend, ack_drv;
  logic [BYTE_W-1:0] new_byte;
  logic              ack_now, is_data;

  always_comb begin
    new_byte = {shreg, sda_s};
    is_data  = (byte_idx >= IDX_W'(FIRST_DATA)) && (byte_idx < IDX_W'(LAST_IDX));
    if (byte_idx == '0) ack_now = (new_byte == ADDR_BYTE);
    else                ack_now = (byte_idx < IDX_W'(LAST_IDX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_idx <= '0;
      ack_pend <= 1'b0;
      ack_drv  <= 1'b0;
      sda_pull <= 1'b0;
      wr       <= '0;
    end else begin
      wr.stb <= 1'b0;
      if (start_det) begin
        phase    <= PH_BITS;
        bit_cnt  <= '0;
        byte_idx <= '0;
        ack_drv  <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        phase    <= PH_IDLE;
        ack_drv  <= 1'b0;
        sda_pull <= 1'b0;
      end else begin
        case (phase)
          PH_BITS: if (scl_rise) begin
            shreg   <= new_byte[BYTE_W-2:0];
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              phase    <= PH_ACK;
              ack_pend <= ack_now;
              if (is_data) begin
                wr.stb  <= 1'b1;
                wr.idx  <= REG_IDX_W'(byte_idx - IDX_W'(FIRST_DATA));
                wr.data <= new_byte;
              end
            end
          end
          PH_ACK: if (scl_fall) begin
            if (!ack_drv) begin
              ack_drv  <= 1'b1;
              sda_pull <= ack_pend;
            end else begin
              ack_drv  <= 1'b0;
              sda_pull <= 1'b0;
              if (byte_idx == '0 && !ack_pend) begin
                phase <= PH_IDLE;
              end else begin
                phase   <= PH_BITS;
                bit_cnt <= '0;
                if (byte_idx != IDX_W'(LAST_IDX)) byte_idx <= byte_idx + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: acknowledge only starts while SCL is low
  a_r2_ack_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);
  // R3: a START always frees the data line
  a_r3_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_pull);
endmodule

// File: rtl/ckb_enable_bank.sv
module ckb_enable_bank
  import ckb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  reg_wr_t            wr,
  input  logic               src_clk,
  output logic [NUM_OUT-1:0] live
);
  logic [NUM_OUT-1:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '1;
    end else if (wr.stb) begin
      case (wr.idx)
        REG_IDX_W'(0): pend[3:0] <= wr.data[3:0];
        REG_IDX_W'(1): pend[7:4] <= wr.data[7:4];
        REG_IDX_W'(2): pend[9:8] <= wr.data[7:6];
        default: ;
      endcase
    end
  end

  // hand over only while the source clock is low
  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) live <= '1;
    else        live <= pend;
  end

  // R11: no strobe ever addresses a register beyond the bank
  a_r11_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr.stb |-> (int'(wr.idx) < NUM_REGS));
  // R10: applied pattern holds through a high phase of the source clock
  a_r10_no_runt: assert property (@(posedge clk) disable iff (!rst_n)
    (src_clk && $past(src_clk)) |-> $stable(live));
endmodule

// File: rtl/ckbank_i2c_ctrl.sv
module ckbank_i2c_ctrl
  import ckb_pkg::*;
(
  input  logic               clk_sys,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_pull,
  input  logic               clk_src,
  input  logic               drive_en,
  output logic [NUM_OUT-1:0] clk_out,
  output logic [NUM_OUT-1:0] clk_oe
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  reg_wr_t wr;
  logic [NUM_OUT-1:0] live;

  ckb_bus_sync #(.STAGES(2)) u_sync (
    .clk(clk_sys), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  ckb_i2c_rx #(.DEV_ADDR(7'b1101001)) u_rx (
    .clk(clk_sys), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .sda_pull(sda_pull), .wr(wr)
  );

  ckb_enable_bank u_bank (
    .clk(clk_sys), .rst_n(rst_n), .wr(wr), .src_clk(clk_src), .live(live)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    assign clk_out[i] = drive_en & live[i] & clk_src;
    assign clk_oe[i]  = drive_en;
  end

  // R8: no output is high while the source clock is low
  a_r8_low_with_src: assert property (@(posedge clk_sys) disable iff (!rst_n)
    !clk_src |-> (clk_out == '0));
  // R9: drive-enable low floats and quiets every output
  a_r9_hiz: assert property (@(posedge clk_sys) disable iff (!rst_n)
    !drive_en |-> (clk_oe == '0 && clk_out == '0));
endmodule

// File: tb/ckbank_i2c_ctrl_test.sv
module ckbank_i2c_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0, scl_drv = 1'b1, sda_drv = 1'b1;
  logic src = 1'b0, drive_en = 1'b1;
  logic sda_pull, sda_line;
  logic [9:0] clk_out, clk_oe;
  logic [9:0] model = '1;
  int checks = 0, errors = 0, runts = 0;
  localparam time Q = 40;

  assign sda_line = sda_drv & ~sda_pull;

  ckbank_i2c_ctrl uut (
    .clk_sys(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_line),
    .sda_pull(sda_pull), .clk_src(src), .drive_en(drive_en),
    .clk_out(clk_out), .clk_oe(clk_oe)
  );

  always #4 clk = ~clk;
  initial begin #3; forever #100 src = ~src; end

  // pulse-width monitor for R10
  logic [9:0] prev_o = '0;
  realtime rt [10];
  always @(clk_out) begin
    for (int i = 0; i < 10; i++) begin
      if (clk_out[i] === 1'b1 && prev_o[i] == 1'b0) rt[i] = $realtime;
      if (clk_out[i] === 1'b0 && prev_o[i] == 1'b1 && ($realtime - rt[i]) < 90.0) runts++;
    end
    prev_o = clk_out;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_drv = 1'b1; scl_drv = 1'b1; #Q;
    sda_drv = 1'b0; #Q;
    scl_drv = 1'b0; #Q;
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; #Q;
    scl_drv = 1'b1; #Q;
    sda_drv = 1'b1; #Q;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; #Q;
      scl_drv = 1'b1; #(2*Q);
      scl_drv = 1'b0; #Q;
    end
    sda_drv = 1'b1; #Q;
    scl_drv = 1'b1; #Q;
    ack = sda_pull; #Q;
    scl_drv = 1'b0; #Q;
  endtask

  task automatic write_txn(input logic [7:0] addr, input int n,
                           input logic [31:0] dat, output logic [7:0] acks);
    logic a;
    acks = '0;
    i2c_start();
    send_byte(addr, a);  acks[0] = a;
    send_byte(8'h5A, a); acks[1] = a;
    send_byte(8'h03, a); acks[2] = a;
    for (int k = 0; k < n; k++) begin
      send_byte(dat[8*k +: 8], a); acks[3+k] = a;
    end
    i2c_stop();
  endtask

  function automatic logic [9:0] apply(logic [9:0] m, int n, logic [31:0] dat);
    if (n > 0) m[3:0] = dat[3:0];
    if (n > 1) m[7:4] = dat[15:12];
    if (n > 2) m[9:8] = dat[23:22];
    return m;
  endfunction

  task automatic observe(string req);
    logic [9:0] eo;
    eo = {10{drive_en}};
    @(negedge src); #20;
    chk({req, " src low"}, {12'h0, clk_oe, clk_out}, {12'h0, eo, 10'b0});
    @(posedge src); #20;
    chk({req, " src high"}, {12'h0, clk_oe, clk_out}, {12'h0, eo, model & eo});
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_500_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] acks;
    logic a;
    logic [31:0] d;
    repeat (6) @(posedge clk);
    #2 rst_n = 1'b1;
    chk("R2 idle no pull", {31'h0, sda_pull}, 32'h0);
    observe("R7 reset all enabled");

    // R1 R2 R4 R5 R6: full write
    d = 32'h0080A005;
    write_txn(8'hD2, 3, d, acks);
    chk("R1/R2/R4 acks full write", {24'h0, acks}, 32'h3F);
    model = apply(model, 3, d);
    observe("R5/R6/R8 full write");

    // R5: early stop leaves later registers alone
    d = 32'h0000000A;
    write_txn(8'hD2, 1, d, acks);
    chk("R5 acks partial", {24'h0, acks}, 32'h0F);
    model = apply(model, 1, d);
    observe("R5 partial write");

    // R6: unused bits ignored
    d = 32'h003F0FF0;
    write_txn(8'hD2, 3, d, acks);
    model = apply(model, 3, d);
    chk("R6 model all off", {22'h0, model}, 32'h0);
    observe("R6 unused bits");

    // R1: wrong address and read bit
    write_txn(8'hD0, 3, 32'h00FFFFFF, acks);
    chk("R1 wrong addr no ack", {24'h0, acks}, 32'h0);
    observe("R1 wrong addr no change");
    write_txn(8'hD3, 3, 32'h00FFFFFF, acks);
    chk("R1 read bit no ack", {24'h0, acks}, 32'h0);
    observe("R1 read bit no change");

    // R11: fourth data byte refused
    d = 32'h00C0F00F;
    write_txn(8'hD2, 4, d, acks);
    chk("R11 extra byte not acked", {24'h0, acks}, 32'h3F);
    model = apply(model, 3, d);
    observe("R11 extra byte ignored");

    // R3: repeated START restarts at register 0
    i2c_start();
    send_byte(8'hD2, a); send_byte(8'h5A, a); send_byte(8'h03, a);
    send_byte(8'h00, a);
    i2c_start();
    send_byte(8'hD2, a); chk("R3 addr ack after restart", {31'h0, a}, 32'h1);
    send_byte(8'h5A, a); send_byte(8'h03, a);
    send_byte(8'h03, a);
    i2c_stop();
    model[3:0] = 4'h3;
    observe("R3 restart");
    // R3: bytes after STOP without START ignored
    send_byte(8'hD2, a);
    chk("R3 no ack without start", {31'h0, a}, 32'h0);
    i2c_stop();
    observe("R3 after stop");

    // R8 R10: sweep of patterns
    for (int v = 0; v < 16; v++) begin
      d = {8'h00, 2'(v), 6'h0, 4'(v), 4'h0, 4'h0, 4'(v)};
      write_txn(8'hD2, 3, d, acks);
      chk("R8 sweep acks", {24'h0, acks}, 32'h3F);
      model = {2'(v), 4'(v), 4'(v)};
      observe("R8/R10 sweep");
    end

    // R9: drive enable low
    @(negedge src); #5 drive_en = 1'b0;
    observe("R9 hi-z");
    write_txn(8'hD2, 3, 32'h00C0F00F, acks);
    model = '1;
    observe("R9 hi-z after write");
    @(negedge src); #5 drive_en = 1'b1;
    observe("R9 restored");

    chk("R10 runt pulses", runts, 0);
    finish_run();
  end
endmodule